// File: doc/BRIEF.md
# Link test frame generator and checker

This block exercises a point-to-point data link for bit-error testing. A generator at the sending end emits an endless stream of fixed-length frames, one word per clock, with no gap between them. Each frame opens with a run of identical header words that carry a fixed marker and the identity of the emitter. The remaining words form the payload, and each payload word packs several small counters that step together from word to word.

A checker at the receiving end first hunts for a complete header that carries the expected emitter identity, and then aligns itself to the frame. Once aligned, it recomputes every payload word from its position in the frame and counts the words that differ. It also counts frames whose header is damaged or carries the wrong identity, and gives up alignment after two such frames in a row. The identity most recently seen in a header word is shown so that a wrongly routed link can be recognised. A test-start pulse clears both counters. The counters and the lock flag are always visible, so a host reads them whenever it wants a report.

In the testbench the generator output is looped back into the checker through a corruption mask.

Top module: `lnk_bert_top`

## Requirements
- R1: A frame is 2048 words long and frames follow each other with no gap. In the first cycle after reset is released, `tx_word` carries word 0 of a frame.
- R2: Frame words 0 to 11 are header words. Each holds the 20-bit marker 0xB5E3C in bits 31:12 and `tx_id` in bits 11:0.
- R3: Payload index p is 0 at frame word 12 and restarts in every frame. Payload word p holds (p+k) mod 64 in bits [6k+5:6k] for k = 0 to 4, and bits 31:30 are zero.
- R4: While unlocked, the checker raises `locked` in the cycle after it has received 12 consecutive words that each equal {marker, `exp_id`}. The next received word is then treated as payload index 0.
- R5: While unlocked, received payload words never change `err_cnt`.
- R6: While locked, every received payload word that differs from the R3 value increments `err_cnt` by exactly one.
- R7: `err_cnt` saturates at 2^ERR_W-1 and does not wrap.
- R8: While locked, a frame with one or more header words unequal to {marker, `exp_id`} increments `hdr_err_cnt` once. One such frame leaves `locked` high. A second such frame immediately after the first drops `locked` when its last header word is received. Unlocked frames are not counted.
- R9: `rx_id` shows bits 11:0 of the latest received word whose bits 31:12 equal the marker. Only words received while hunting or in a header position are considered.
- R10: `test_start` clears both counters on the next clock edge and takes precedence over an increment in the same cycle. `locked` is not affected.
- R11: After reset, `locked` is 0 and `err_cnt`, `hdr_err_cnt` and `rx_id` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_id | input | 12 | Emitter identity placed in the header |
| tx_word | output | 32 | Generated link word |
| rx_word | input | 32 | Received link word |
| exp_id | input | 12 | Identity the checker expects |
| test_start | input | 1 | Pulse that clears the error counters |
| locked | output | 1 | Checker is aligned to the frame |
| err_cnt | output | ERR_W (16) | Saturating count of payload word errors |
| hdr_err_cnt | output | HDR_CNT_W (8) | Saturating count of bad-header frames |
| rx_id | output | 12 | Identity from the latest header-marked word |

## Verification
Clean looped-back frames confirm alignment on the very first header and show that the generator and the checker agree on every payload word. Payload corruption comes in three forms: sparse random masks count word by word, which separates one count per bad word from one count per bad bit. Corruption of every payload word drives the error count into saturation. Errors injected in the same cycle as the clear pulse show which of the two wins. Header patterns check the lock logic. A wrong identity in a single frame, followed by a clean frame, must keep lock. Two bad-header frames in a row must drop it. A broken marker in the middle of a header while hunting must delay relock by a full frame. Payload errors while unlocked must leave the count unchanged.

// File: rtl/lnk_bert_pkg.sv
// Shared definitions for the link test frame generator and checker.
// Holds the default frame geometry and the checker state type.
package lnk_bert_pkg;

    localparam int DEF_WORD_W    = 32;
    localparam int DEF_ID_W      = 12;
    localparam int DEF_CNT_W     = 6;
    localparam int DEF_NUM_CNT   = 5;
    localparam int DEF_HDR_LEN   = 12;
    localparam int DEF_FRAME_LEN = 2048;
    localparam logic [DEF_WORD_W-DEF_ID_W-1:0] DEF_MARKER = 20'hB5E3C;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } chk_state_t;

endpackage

// File: rtl/lnk_ref_word.sv
// Reference word former.
// Computes the frame word at position pos: a header word {MARKER, id} for the
// first HDR_LEN positions, and otherwise NUM_CNT counter fields, each holding
// (payload index + field number) mod 2^CNT_W, with the unused top bits zero.
// Assumes NUM_CNT*CNT_W <= WORD_W and that the marker's top bit is set, so
// that a payload word can never carry the marker.
module lnk_ref_word import lnk_bert_pkg::*; #(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ID_W      = DEF_ID_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_CNT   = DEF_NUM_CNT,
    parameter int HDR_LEN   = DEF_HDR_LEN,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter logic [WORD_W-ID_W-1:0] MARKER = DEF_MARKER,
    localparam int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic [IDX_W-1:0]  pos,
    input  logic [ID_W-1:0]   id,
    output logic [WORD_W-1:0] word,
    output logic              is_hdr
);

    localparam int FILL_W = NUM_CNT * CNT_W;

    logic [IDX_W-1:0]  pay_idx;
    logic [WORD_W-1:0] hdr_w;
    logic [WORD_W-1:0] pay_w;

    // Header or payload region, and index inside the payload
    assign is_hdr  = (pos < IDX_W'(HDR_LEN));
    assign pay_idx = pos - IDX_W'(HDR_LEN);
    assign hdr_w   = {MARKER, id};

    // One counter field per lane, offset by its lane number
    generate
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
            assign pay_w[k*CNT_W +: CNT_W] = CNT_W'(pay_idx + IDX_W'(k));
        end
        if (FILL_W < WORD_W) begin : g_pad
            assign pay_w[WORD_W-1:FILL_W] = '0;
        end
    endgenerate

    // Select the word for this position
    assign word = is_hdr ? hdr_w : pay_w;

endmodule

// File: rtl/lnk_sat_counter.sv
// Saturating event counter.
// Counts single-cycle increment pulses, stops at all ones, and is cleared by
// a synchronous clear that takes precedence over an increment.
module lnk_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count, hold at the top value, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !(&cnt)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: without a clear the count moves by at most one per cycle
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

    // R7: once saturated the count stays there until cleared
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt && !clr) |=> &cnt);

endmodule

// File: rtl/lnk_frame_gen.sv
// Test frame generator.
// Emits one word per cycle from a free-running position counter that wraps
// at FRAME_LEN, so frames follow each other with no gap.
// Assumes tx_id is stable for the duration of a test.
module lnk_frame_gen import lnk_bert_pkg::*; #(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ID_W      = DEF_ID_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_CNT   = DEF_NUM_CNT,
    parameter int HDR_LEN   = DEF_HDR_LEN,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter logic [WORD_W-ID_W-1:0] MARKER = DEF_MARKER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   tx_id,
    output logic [WORD_W-1:0] tx_word
);

    localparam int IDX_W  = $clog2(FRAME_LEN);
    localparam int MARK_W = WORD_W - ID_W;

    logic [IDX_W-1:0] idx;
    logic             in_hdr;

    // Position inside the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (idx == IDX_W'(FRAME_LEN - 1)) begin
            idx <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    lnk_ref_word #(
        .WORD_W(WORD_W), .ID_W(ID_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT),
        .HDR_LEN(HDR_LEN), .FRAME_LEN(FRAME_LEN), .MARKER(MARKER)
    ) u_form (
        .pos(idx), .id(tx_id), .word(tx_word), .is_hdr(in_hdr)
    );

    // R2: every header position carries the marker
    p_hdr_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr |-> tx_word[WORD_W-1 -: MARK_W] == MARKER);

    // R3: lane 0 steps by one between consecutive payload words
    p_field_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx > IDX_W'(HDR_LEN)) |-> tx_word[CNT_W-1:0] == $past(tx_word[CNT_W-1:0]) + CNT_W'(1));

endmodule

// File: rtl/lnk_frame_chk.sv
// Test frame checker.
// Hunts for HDR_LEN consecutive header words carrying the expected identity,
// then tracks the frame position and compares every received word with the
// reference word for that position. Counts bad payload words and bad-header
// frames, and drops lock after two bad-header frames in a row.
// Assumes the link delivers one word per cycle with no gaps.
module lnk_frame_chk import lnk_bert_pkg::*; #(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ID_W      = DEF_ID_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_CNT   = DEF_NUM_CNT,
    parameter int HDR_LEN   = DEF_HDR_LEN,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter int ERR_W     = 16,
    parameter int HDR_CNT_W = 8,
    parameter logic [WORD_W-ID_W-1:0] MARKER = DEF_MARKER
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    rx_word,
    input  logic [ID_W-1:0]      exp_id,
    input  logic                 test_start,
    output logic                 locked,
    output logic [ERR_W-1:0]     err_cnt,
    output logic [HDR_CNT_W-1:0] hdr_err_cnt,
    output logic [ID_W-1:0]      rx_id
);

    localparam int IDX_W  = $clog2(FRAME_LEN);
    localparam int RUN_W  = $clog2(HDR_LEN + 1);
    localparam int MARK_W = WORD_W - ID_W;

    chk_state_t        state;
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  ref_pos;
    logic [RUN_W-1:0]  run;
    logic              hdr_bad;
    logic              prev_bad;
    logic [WORD_W-1:0] exp_word;
    logic              exp_is_hdr;
    logic              word_ok;
    logic              marker_ok;
    logic              pay_err;
    logic              last_hdr;
    logic              frame_bad;
    logic              hdr_evt;
    logic              lose;
    logic              gain;

    // While hunting, compare against the header word (position 0)
    assign ref_pos = (state == ST_TRACK) ? pos : '0;

    lnk_ref_word #(
        .WORD_W(WORD_W), .ID_W(ID_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT),
        .HDR_LEN(HDR_LEN), .FRAME_LEN(FRAME_LEN), .MARKER(MARKER)
    ) u_ref (
        .pos(ref_pos), .id(exp_id), .word(exp_word), .is_hdr(exp_is_hdr)
    );

    // Per-cycle decisions on the received word
    assign word_ok   = (rx_word == exp_word);
    assign marker_ok = (rx_word[WORD_W-1 -: MARK_W] == MARKER);
    assign pay_err   = (state == ST_TRACK) && !exp_is_hdr && !word_ok;
    assign last_hdr  = (state == ST_TRACK) && (pos == IDX_W'(HDR_LEN - 1));
    assign frame_bad = hdr_bad || !word_ok;
    assign hdr_evt   = last_hdr && frame_bad;
    assign lose      = hdr_evt && prev_bad;
    assign gain      = (state == ST_HUNT) && word_ok && (run == RUN_W'(HDR_LEN - 1));
    assign locked    = (state == ST_TRACK);

    // Alignment state, header run length and frame position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            pos   <= '0;
            run   <= '0;
        end else if (state == ST_HUNT) begin
            if (gain) begin
                state <= ST_TRACK;
                pos   <= IDX_W'(HDR_LEN);
                run   <= '0;
            end else begin
                run <= word_ok ? run + 1'b1 : '0;
            end
        end else begin
            if (lose) begin
                state <= ST_HUNT;
                pos   <= '0;
            end else begin
                pos <= (pos == IDX_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
            end
        end
    end

    // Header health of the current frame and of the previous one
    always_ff @(posedge clk) begin
        if (!rst_n || gain) begin
            hdr_bad  <= 1'b0;
            prev_bad <= 1'b0;
        end else if ((state == ST_TRACK) && exp_is_hdr) begin
            if (last_hdr) begin
                hdr_bad  <= 1'b0;
                prev_bad <= frame_bad;
            end else begin
                hdr_bad <= frame_bad;
            end
        end
    end

    // Identity seen in the latest marker-carrying word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_id <= '0;
        end else if (marker_ok && ((state == ST_HUNT) || exp_is_hdr)) begin
            rx_id <= rx_word[ID_W-1:0];
        end
    end

    lnk_sat_counter #(.W(ERR_W)) u_err_cnt (
        .clk(clk), .rst_n(rst_n), .clr(test_start), .inc(pay_err), .cnt(err_cnt)
    );

    lnk_sat_counter #(.W(HDR_CNT_W)) u_hdr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(test_start), .inc(hdr_evt), .cnt(hdr_err_cnt)
    );

    // R4: lock is only gained on a word equal to the expected header
    p_lock_on_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rx_word) == {MARKER, $past(exp_id)});

    // R5: no payload errors are counted while hunting
    p_idle_hunt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !test_start) |=> err_cnt == $past(err_cnt));

    // R8: losing lock always comes with a counted bad header
    p_drop_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && !$past(test_start)) |-> (hdr_err_cnt != $past(hdr_err_cnt)) || (&hdr_err_cnt));

endmodule

// File: rtl/lnk_bert_top.sv
// Link bit-error test block: frame generator and frame checker side by side.
// The generator drives tx_word; the checker consumes rx_word, which the
// surrounding logic connects to the far end of the link under test.
module lnk_bert_top import lnk_bert_pkg::*; #(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ID_W      = DEF_ID_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_CNT   = DEF_NUM_CNT,
    parameter int HDR_LEN   = DEF_HDR_LEN,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter int ERR_W     = 16,
    parameter int HDR_CNT_W = 8,
    parameter logic [WORD_W-ID_W-1:0] MARKER = DEF_MARKER
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      tx_id,
    output logic [WORD_W-1:0]    tx_word,
    input  logic [WORD_W-1:0]    rx_word,
    input  logic [ID_W-1:0]      exp_id,
    input  logic                 test_start,
    output logic                 locked,
    output logic [ERR_W-1:0]     err_cnt,
    output logic [HDR_CNT_W-1:0] hdr_err_cnt,
    output logic [ID_W-1:0]      rx_id
);

    lnk_frame_gen #(
        .WORD_W(WORD_W), .ID_W(ID_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT),
        .HDR_LEN(HDR_LEN), .FRAME_LEN(FRAME_LEN), .MARKER(MARKER)
    ) u_gen (
        .clk(clk), .rst_n(rst_n), .tx_id(tx_id), .tx_word(tx_word)
    );

    lnk_frame_chk #(
        .WORD_W(WORD_W), .ID_W(ID_W), .CNT_W(CNT_W), .NUM_CNT(NUM_CNT),
        .HDR_LEN(HDR_LEN), .FRAME_LEN(FRAME_LEN), .ERR_W(ERR_W),
        .HDR_CNT_W(HDR_CNT_W), .MARKER(MARKER)
    ) u_chk (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .exp_id(exp_id),
        .test_start(test_start), .locked(locked), .err_cnt(err_cnt),
        .hdr_err_cnt(hdr_err_cnt), .rx_id(rx_id)
    );

endmodule

// File: tb/sim_lnk_bert_top.sv
// Testbench: generator looped back into the checker through a corruption mask.
module sim_lnk_bert_top;

    localparam int FL = 2048;
    localparam int HL = 12;
    localparam int CW = 6;
    localparam int NC = 5;
    localparam int EW = 10;
    localparam int HW = 8;
    localparam logic [19:0] MK  = 20'hB5E3C;
    localparam logic [11:0] TID = 12'h5A3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   tx_word;
    logic [31:0]   rx_word;
    logic [31:0]   flip = '0;
    logic          test_start = 1'b0;
    logic          locked;
    logic [EW-1:0] err_cnt;
    logic [HW-1:0] hdr_err_cnt;
    logic [11:0]   rx_id;

    int n_tests = 0;
    int n_fail  = 0;
    int bpos    = 0;
    int n_inj, first_lock, snap_err, snap_lock;
    int gen_hdr_mis = 0;
    int gen_pay_mis = 0;
    int err_before;

    always #4 clk = ~clk;

    assign rx_word = tx_word ^ flip;

    lnk_bert_top #(.ERR_W(EW), .HDR_CNT_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_id(TID), .tx_word(tx_word),
        .rx_word(rx_word), .exp_id(TID), .test_start(test_start),
        .locked(locked), .err_cnt(err_cnt), .hdr_err_cnt(hdr_err_cnt), .rx_id(rx_id)
    );

    // Expected frame word at a position (R2 header, R3 payload)
    function automatic logic [31:0] exp_word(input int pos);
        logic [31:0] w = '0;
        if (pos < HL) return {MK, TID};
        for (int k = 0; k < NC; k++) w[k*CW +: CW] = 6'((pos - HL + k) % 64);
        return w;
    endfunction

    function automatic logic [31:0] rnd_mask();
        logic [31:0] v = $urandom;
        return (v == 0) ? 32'h1 : v;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        bpos = (bpos + 1) % FL;
        @(negedge clk);
    endtask

    // Drive one frame from position 0; pay_mode 0 clean, 1 sparse, 2 all words
    task automatic drive_frame(input logic [11:0] id_flip, input int bad_word,
                               input int pay_mode, input int clr_at);
        n_inj = 0;
        first_lock = -1;
        do begin
            logic [31:0] m;
            m = '0;
            if (bpos < HL) begin
                m[11:0] = id_flip;
                if (bpos == bad_word) m[31] = 1'b1;
            end else if (pay_mode == 2) begin
                m = rnd_mask();
            end else if (pay_mode == 1 && ((($urandom % 64) == 0) || bpos == clr_at)) begin
                m = rnd_mask();
            end
            if (m != 0 && bpos >= HL && bpos > clr_at) n_inj++;
            if (bpos < HL && tx_word !== exp_word(bpos)) gen_hdr_mis++;
            if (bpos >= HL && tx_word !== exp_word(bpos)) gen_pay_mis++;
            if (locked && first_lock < 0) first_lock = bpos;
            if (clr_at >= 0 && bpos == clr_at + 1) begin
                snap_err  = int'(err_cnt);
                snap_lock = int'(locked);
            end
            test_start = (bpos == clr_at);
            flip = m;
            tick();
        end while (bpos != 0);
        flip = '0;
        test_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bpos = 0;

        // R11: reset state
        chk("R11 locked after reset", locked, 0);
        chk("R11 err_cnt after reset", err_cnt, 0);
        chk("R11 hdr_err_cnt after reset", hdr_err_cnt, 0);
        chk("R11 rx_id after reset", rx_id, 0);
        // R1: word 0 right after reset release
        chk("R1 first word is header", tx_word, exp_word(0));

        // Frame 1: clean, lock after the first header
        drive_frame(12'h0, -1, 0, -1);
        chk("R4 lock position in first frame", first_lock, HL);
        chk("R1 next frame starts after 2048 words", tx_word, exp_word(0));
        chk("R9 rx_id after good header", rx_id, TID);
        chk("R6 clean frame has no errors", err_cnt, 0);

        // Frames 2-3: sparse random payload errors
        drive_frame(12'h0, -1, 1, -1);
        chk("R6 sparse errors frame 2", err_cnt, n_inj);
        err_before = n_inj;
        drive_frame(12'h0, -1, 1, -1);
        chk("R6 sparse errors frame 3 cumulative", err_cnt, err_before + n_inj);
        chk("R8 no header errors on clean headers", hdr_err_cnt, 0);

        // Frame 4: clear pulse in the same cycle as an error
        drive_frame(12'h0, -1, 1, 100);
        chk("R10 clear wins over increment", snap_err, 0);
        chk("R10 lock kept across clear", snap_lock, 1);
        chk("R6 errors counted after clear", err_cnt, n_inj);
        err_before = int'(err_cnt);

        // Frame 5: wrong identity in one frame keeps lock
        drive_frame(12'h0F0, -1, 0, -1);
        chk("R8 one bad header counted", hdr_err_cnt, 1);
        chk("R8 lock kept after one bad header", locked, 1);
        chk("R9 rx_id shows received identity", rx_id, TID ^ 12'h0F0);
        // Frame 6: clean
        drive_frame(12'h0, -1, 0, -1);
        chk("R8 good header not counted", hdr_err_cnt, 1);
        chk("R9 rx_id back to emitter", rx_id, TID);
        // Frames 7-8: two bad headers in a row
        drive_frame(12'h00F, -1, 0, -1);
        chk("R8 lock kept after first of two", locked, 1);
        drive_frame(12'h0, 4, 1, -1);
        chk("R8 lock dropped after second bad header", locked, 0);
        chk("R8 header error count", hdr_err_cnt, 3);
        chk("R5 payload ignored after lock loss", err_cnt, err_before);

        // Frame 9: broken marker in the header while hunting
        drive_frame(12'h0, 3, 1, -1);
        chk("R4 no lock on partial header run", locked, 0);
        chk("R5 payload ignored while hunting", err_cnt, err_before);
        chk("R8 hunting frames not counted", hdr_err_cnt, 3);

        // Frame 10: clean relock
        drive_frame(12'h0, -1, 0, -1);
        chk("R4 relock position", first_lock, HL);

        // Frames 11-12: saturation
        drive_frame(12'h0, -1, 2, -1);
        chk("R7 error count saturates", err_cnt, (1 << EW) - 1);
        drive_frame(12'h0, -1, 1, -1);
        chk("R7 saturated count holds", err_cnt, (1 << EW) - 1);

        chk("R2 generator header words", gen_hdr_mis, 0);
        chk("R3 generator payload words", gen_pay_mis, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule